// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block chooses which ready instructions leave the scheduler each cycle. Every operation class has a small ready queue of its own. An entry carries a sequence number, a thread id and a memory flag. The head of a class is its waiting entry with the lowest sequence number. Each cycle the selector walks the class heads from oldest to youngest and fills up to `WIDTH` execute slots. A walk step is skipped when that class has no free functional unit. A step drops the head when the head is flagged as squashed.

One class needs no functional unit. Classes whose issue latency exceeds one do not enter a slot when they are picked. Their instruction is held in a per-class delay register and is delivered to a slot later. Deliveries that mature take slots ahead of new picks. A delivery that finds no free slot waits in its delay register.

On issue, a non-memory entry leaves its queue. A memory entry stays in place, no longer eligible, until a completion names it. The block reports the per-thread occupancy and a per-class full flag.

Top module: `issue_select`

## Requirements
- R1: A push into class c is accepted when its queue holds fewer than `QDEPTH` entries. `q_full[c]` is high exactly when the queue holds `QDEPTH` entries, and a push into a full queue is ignored.
- R2: The head of a class is its waiting (not issued) entry with the lowest sequence number, compared as unsigned values, whatever order the entries were pushed in.
- R3: Class heads are visited in increasing sequence number, with ties going to the lower class index. New issues fill the slots that the matured deliveries leave free, in that same age order, starting from the lowest free slot index.
- R4: At most `WIDTH` slots are filled per cycle. Once every slot is used, the remaining heads are left untouched that cycle: they are not issued, not dropped and not started on a delay.
- R5: A head whose `head_squash` bit is high when the walk reaches it is removed without using a slot, and the walk goes on to the next class.
- R6: A class other than `NOFU` whose `fu_free` bit is low, or whose delay register is busy, is skipped, and its head stays in the queue.
- R7: Class `NOFU` (default 0) issues regardless of `fu_free` and never raises `fu_release`.
- R8: A class whose issue latency is at most 1 appears on the `exe_*` outputs the cycle after it is selected. For a class other than `NOFU`, `fu_release` pulses in that same cycle.
- R9: A class with issue latency L > 1 uses no slot when it is picked. It is delivered L-1 cycles later than a latency-1 issue would be, together with its `fu_release` pulse. Issue latency is the 4-bit field `ISSUE_LAT[4c+3:4c]`, and the default makes class 3 latency 3 and all other classes latency 1.
- R10: Matured deliveries take slots before new issues, in increasing class index, and a delivery that does not fit waits to the next cycle.
- R11: `thr_count` field t (bits `[t*CW +: CW]`) counts the entries held for thread t. A non-memory instruction leaves on issue. A memory instruction stays until `done_valid` names its class and sequence number.
- R12: After reset all queues are empty, no delay is in flight, and `exe_valid`, `fu_release`, `q_full` and `thr_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | NCLS | Push request per class |
| push_seq | input | NCLS*SEQW | Sequence number per class push |
| push_tid | input | NCLS*TIDW | Thread id per class push |
| push_mem | input | NCLS | Memory flag per class push |
| q_full | output | NCLS | Class queue is full |
| head_squash | input | NCLS | Current head of the class is squashed |
| fu_free | input | NCLS | A unit of the class is available this cycle |
| fu_release | output | NCLS | Unit of the class handed back |
| done_valid | input | 1 | Memory completion strobe |
| done_cls | input | CLSW | Class of the completing memory entry |
| done_seq | input | SEQW | Sequence number of the completing memory entry |
| exe_valid | output | WIDTH | Execute slot occupied |
| exe_seq | output | WIDTH*SEQW | Sequence number per slot |
| exe_tid | output | WIDTH*TIDW | Thread id per slot |
| exe_cls | output | WIDTH*CLSW | Class per slot |
| thr_count | output | NTHR*CW | Entries held per thread |

## Verification
A push becomes visible to selection one cycle after its edge. A selection made in a cycle shows up on `exe_*` and `fu_release` one edge later. A delayed class shows up L-1 edges after that, or later still if the slots are full. `q_full` and `thr_count` follow the queue state that each edge produces. The bench steps a behavioural model of the queues and delay registers once per clock, using the inputs held across the edge. It compares every output one nanosecond after the edge, so each result is sampled in exactly the cycle the timing above places it.

// File: rtl/issue_select.sv
module issue_select #(
  parameter int NCLS = 4,
  parameter int QDEPTH = 4,
  parameter int SEQW = 10,
  parameter int TIDW = 1,
  parameter int WIDTH = 2,
  parameter int NOFU = 0,
  parameter logic [4*NCLS-1:0] ISSUE_LAT = 16'h3111,
  localparam int CLSW = (NCLS > 1) ? $clog2(NCLS) : 1,
  localparam int QIW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
  localparam int SLW = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int NTHR = 1 << TIDW,
  localparam int CW = $clog2(NCLS*QDEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCLS-1:0]        push_valid,
  input  logic [NCLS*SEQW-1:0]   push_seq,
  input  logic [NCLS*TIDW-1:0]   push_tid,
  input  logic [NCLS-1:0]        push_mem,
  output logic [NCLS-1:0]        q_full,
  input  logic [NCLS-1:0]        head_squash,
  input  logic [NCLS-1:0]        fu_free,
  output logic [NCLS-1:0]        fu_release,
  input  logic                   done_valid,
  input  logic [CLSW-1:0]        done_cls,
  input  logic [SEQW-1:0]        done_seq,
  output logic [WIDTH-1:0]       exe_valid,
  output logic [WIDTH*SEQW-1:0]  exe_seq,
  output logic [WIDTH*TIDW-1:0]  exe_tid,
  output logic [WIDTH*CLSW-1:0]  exe_cls,
  output logic [NTHR*CW-1:0]     thr_count
);

  function automatic int lat_of(input int c);
    return int'(ISSUE_LAT[4*c +: 4]);
  endfunction

  logic            e_vld  [NCLS][QDEPTH];
  logic            e_held [NCLS][QDEPTH];
  logic            e_mem  [NCLS][QDEPTH];
  logic [SEQW-1:0] e_seq  [NCLS][QDEPTH];
  logic [TIDW-1:0] e_tid  [NCLS][QDEPTH];

  logic [NCLS-1:0] dv;
  logic [3:0]      dcnt [NCLS];
  logic [SEQW-1:0] dseq [NCLS];
  logic [TIDW-1:0] dtid [NCLS];

  logic [NCLS-1:0] hv, pok, mat, mtake, ok, takes, drop, iss;
  logic [SEQW-1:0] hs   [NCLS];
  logic [QIW-1:0]  hidx [NCLS];
  logic [QIW-1:0]  pidx [NCLS];
  int              mslot [NCLS];
  int              islot [NCLS];
  int              ntaken, bef;

  logic [WIDTH-1:0] xv;
  logic [SEQW-1:0]  xs [WIDTH];
  logic [TIDW-1:0]  xt [WIDTH];
  logic [CLSW-1:0]  xc [WIDTH];
  logic [SEQW-1:0]  rs [WIDTH];
  logic [TIDW-1:0]  rt [WIDTH];
  logic [CLSW-1:0]  rc [WIDTH];

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      hv[c] = 1'b0; hs[c] = '0; hidx[c] = '0;
      pok[c] = 1'b0; pidx[c] = '0;
      for (int k = 0; k < QDEPTH; k++) begin
        if (e_vld[c][k] && !e_held[c][k] && (!hv[c] || e_seq[c][k] < hs[c])) begin
          hv[c] = 1'b1; hs[c] = e_seq[c][k]; hidx[c] = QIW'(k);
        end
        if (!e_vld[c][k] && !pok[c]) begin
          pok[c] = 1'b1; pidx[c] = QIW'(k);
        end
      end
    end
  end

  assign q_full = ~pok;

  always_comb begin
    ntaken = 0;
    bef = 0;
    for (int c = 0; c < NCLS; c++) begin
      mat[c]   = dv[c] && (dcnt[c] == 4'd0);
      ok[c]    = (c == NOFU) || (fu_free[c] && !dv[c]);
      takes[c] = hv[c] && !head_squash[c] && ok[c] && (lat_of(c) <= 1);
      mtake[c] = 1'b0;
      mslot[c] = 0;
      if (mat[c] && ntaken < WIDTH) begin
        mtake[c] = 1'b1; mslot[c] = ntaken; ntaken = ntaken + 1;
      end
    end
    for (int c = 0; c < NCLS; c++) begin
      bef = 0;
      for (int d = 0; d < NCLS; d++)
        if (d != c && takes[d] && (hs[d] < hs[c] || (hs[d] == hs[c] && d < c)))
          bef = bef + 1;
      drop[c]  = hv[c] && (bef < WIDTH - ntaken) && head_squash[c];
      iss[c]   = hv[c] && (bef < WIDTH - ntaken) && !head_squash[c] && ok[c];
      islot[c] = ntaken + bef;
    end
  end

  always_comb begin
    xv = '0;
    for (int s = 0; s < WIDTH; s++) begin
      xs[s] = '0; xt[s] = '0; xc[s] = '0;
    end
    for (int c = 0; c < NCLS; c++) begin
      if (mtake[c]) begin
        xv[SLW'(mslot[c])] = 1'b1;
        xs[SLW'(mslot[c])] = dseq[c];
        xt[SLW'(mslot[c])] = dtid[c];
        xc[SLW'(mslot[c])] = CLSW'(c);
      end
      if (iss[c] && lat_of(c) <= 1) begin
        xv[SLW'(islot[c])] = 1'b1;
        xs[SLW'(islot[c])] = hs[c];
        xt[SLW'(islot[c])] = e_tid[c][hidx[c]];
        xc[SLW'(islot[c])] = CLSW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCLS; c++) begin
        for (int k = 0; k < QDEPTH; k++) begin
          e_vld[c][k] <= 1'b0; e_held[c][k] <= 1'b0; e_mem[c][k] <= 1'b0;
          e_seq[c][k] <= '0;   e_tid[c][k] <= '0;
        end
        dcnt[c] <= '0; dseq[c] <= '0; dtid[c] <= '0;
      end
      dv <= '0;
      fu_release <= '0;
      exe_valid <= '0;
      for (int s = 0; s < WIDTH; s++) begin
        rs[s] <= '0; rt[s] <= '0; rc[s] <= '0;
      end
    end else begin
      for (int c = 0; c < NCLS; c++) begin
        if (drop[c] || (iss[c] && !e_mem[c][hidx[c]])) e_vld[c][hidx[c]] <= 1'b0;
        else if (iss[c]) e_held[c][hidx[c]] <= 1'b1;
        for (int k = 0; k < QDEPTH; k++)
          if (done_valid && done_cls == CLSW'(c) && e_vld[c][k] && e_held[c][k] &&
              e_seq[c][k] == done_seq)
            e_vld[c][k] <= 1'b0;
        if (push_valid[c] && pok[c]) begin
          e_vld[c][pidx[c]]  <= 1'b1;
          e_held[c][pidx[c]] <= 1'b0;
          e_mem[c][pidx[c]]  <= push_mem[c];
          e_seq[c][pidx[c]]  <= push_seq[c*SEQW +: SEQW];
          e_tid[c][pidx[c]]  <= push_tid[c*TIDW +: TIDW];
        end
        if (mtake[c]) dv[c] <= 1'b0;
        else if (dv[c] && dcnt[c] != 4'd0) dcnt[c] <= dcnt[c] - 4'd1;
        if (iss[c] && lat_of(c) > 1) begin
          dv[c]   <= 1'b1;
          dcnt[c] <= 4'(lat_of(c) - 2);
          dseq[c] <= hs[c];
          dtid[c] <= e_tid[c][hidx[c]];
        end
        fu_release[c] <= mtake[c] || (iss[c] && lat_of(c) <= 1 && c != NOFU);
      end
      exe_valid <= xv;
      for (int s = 0; s < WIDTH; s++) begin
        rs[s] <= xs[s]; rt[s] <= xt[s]; rc[s] <= xc[s];
      end
    end
  end

  for (genvar s = 0; s < WIDTH; s++) begin : g_out
    assign exe_seq[s*SEQW +: SEQW] = rs[s];
    assign exe_tid[s*TIDW +: TIDW] = rt[s];
    assign exe_cls[s*CLSW +: CLSW] = rc[s];
  end

  always_comb begin
    thr_count = '0;
    for (int t = 0; t < NTHR; t++)
      for (int c = 0; c < NCLS; c++)
        for (int k = 0; k < QDEPTH; k++)
          if (e_vld[c][k] && e_tid[c][k] == TIDW'(t))
            thr_count[t*CW +: CW] = thr_count[t*CW +: CW] + CW'(1);
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_chk
    for (genvar k = 0; k < QDEPTH; k++) begin : g_ent
      a_r2_head_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        (e_vld[c][k] && !e_held[c][k]) |-> (hv[c] && hs[c] <= e_seq[c][k]));
    end
    a_r9_inflight: assert property (@(posedge clk) disable iff (!rst_n)
      (dv[c] && dcnt[c] != 4'd0) |=> dv[c]);
    a_r10_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (mat[c] && !mtake[c]) |=> mat[c]);
    a_r6_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (hv[c] && !ok[c] && !head_squash[c]) |=> hv[c]);
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      fu_release[c] |-> $past(iss[c] || mtake[c]));
  end

  for (genvar s = 1; s < WIDTH; s++) begin : g_pack
    a_r3_packed: assert property (@(posedge clk) disable iff (!rst_n)
      exe_valid[s] |-> exe_valid[s-1]);
  end

endmodule

// File: tb/sim_issue_select.sv
`timescale 1ns/1ps
module sim_issue_select;
  localparam int NC = 4, QD = 4, SW = 10, WD = 2, CWB = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] push_valid = '0, push_mem = '0, head_squash = '0, fu_free = '0;
  logic [NC*SW-1:0] push_seq = '0;
  logic [NC-1:0] push_tid = '0;
  logic [NC-1:0] q_full, fu_release;
  logic done_valid = 1'b0;
  logic [1:0] done_cls = '0;
  logic [SW-1:0] done_seq = '0;
  logic [WD-1:0] exe_valid;
  logic [WD*SW-1:0] exe_seq;
  logic [WD-1:0] exe_tid;
  logic [WD*2-1:0] exe_cls;
  logic [2*CWB-1:0] thr_count;

  issue_select u0 (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_seq(push_seq),
    .push_tid(push_tid), .push_mem(push_mem), .q_full(q_full),
    .head_squash(head_squash), .fu_free(fu_free), .fu_release(fu_release),
    .done_valid(done_valid), .done_cls(done_cls), .done_seq(done_seq),
    .exe_valid(exe_valid), .exe_seq(exe_seq), .exe_tid(exe_tid),
    .exe_cls(exe_cls), .thr_count(thr_count));

  always #2.5 clk = ~clk;

  typedef struct {int seq; int tid; bit mem; bit held;} ent_t;
  ent_t mq[NC][$];
  bit mdv[NC];
  int mcnt[NC], mseq[NC], mtid[NC];
  int lat[NC] = '{1, 1, 1, 3};
  int errs = 0, nchk = 0, gs = 100;

  task automatic chk(input bit good, input string what, input int act, input int exp);
    nchk++;
    if (!good) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic setpush(input int c, input int seq, input int tid, input bit mem);
    push_valid[c] = 1'b1;
    push_seq[c*SW +: SW] = SW'(seq);
    push_tid[c] = tid[0];
    push_mem[c] = mem;
  endtask

  task automatic clr();
    push_valid = '0; head_squash = '0; done_valid = 1'b0;
  endtask

  // one clock of the reference model, then compare every output
  task automatic cyc();
    int hsq[NC], hix[NC], ev[WD], es[WD], et[WD], ec[WD], nsq[NC], ntd[NC];
    bit full_pre[NC], taken[NC], newd[NC], vis[NC], erel[NC];
    int used;
    used = 0;
    for (int s = 0; s < WD; s++) begin ev[s] = 0; es[s] = 0; et[s] = 0; ec[s] = 0; end
    for (int c = 0; c < NC; c++) begin
      full_pre[c] = mq[c].size() >= QD;
      taken[c] = 0; newd[c] = 0; vis[c] = 0; erel[c] = 0; hix[c] = -1; hsq[c] = 0;
      nsq[c] = 0; ntd[c] = 0;
      foreach (mq[c][i])
        if (!mq[c][i].held && (hix[c] < 0 || mq[c][i].seq < hsq[c])) begin
          hix[c] = i; hsq[c] = mq[c][i].seq;
        end
    end
    for (int c = 0; c < NC; c++)
      if (mdv[c] && mcnt[c] == 0 && used < WD) begin
        ev[used] = 1; es[used] = mseq[c]; et[used] = mtid[c]; ec[used] = c;
        erel[c] = 1; taken[c] = 1; used++;
      end
    for (int n = 0; n < NC; n++) begin
      automatic int b = -1;
      for (int c = 0; c < NC; c++)
        if (!vis[c] && hix[c] >= 0 && (b < 0 || hsq[c] < hsq[b])) b = c;
      if (b < 0) break;
      vis[b] = 1;
      if (used >= WD) break;
      if (head_squash[b]) begin mq[b].delete(hix[b]); continue; end
      if (!(b == 0 || (fu_free[b] && !mdv[b]))) continue;
      if (lat[b] <= 1) begin
        ev[used] = 1; es[used] = hsq[b]; et[used] = mq[b][hix[b]].tid; ec[used] = b;
        if (b != 0) erel[b] = 1;
        used++;
      end else begin
        newd[b] = 1; nsq[b] = hsq[b]; ntd[b] = mq[b][hix[b]].tid;
      end
      if (mq[b][hix[b]].mem) mq[b][hix[b]].held = 1;
      else mq[b].delete(hix[b]);
    end
    if (done_valid) begin
      automatic int dc = int'(done_cls);
      for (int i = 0; i < mq[dc].size(); i++)
        if (mq[dc][i].held && mq[dc][i].seq == int'(done_seq)) begin
          mq[dc].delete(i); break;
        end
    end
    for (int c = 0; c < NC; c++) begin
      if (push_valid[c] && !full_pre[c])
        mq[c].push_back('{int'(push_seq[c*SW +: SW]), int'(push_tid[c]), push_mem[c], 1'b0});
      if (taken[c]) mdv[c] = 0;
      else if (mdv[c] && mcnt[c] > 0) mcnt[c]--;
      if (newd[c]) begin mdv[c] = 1; mcnt[c] = lat[c] - 2; mseq[c] = nsq[c]; mtid[c] = ntd[c]; end
    end
    @(posedge clk); #1;
    for (int s = 0; s < WD; s++) begin
      chk(exe_valid[s] == ev[s][0], "R3 R4 R5 R6 R10 exe_valid", int'(exe_valid[s]), ev[s]);
      if (ev[s] != 0) begin
        chk(int'(exe_seq[s*SW +: SW]) == es[s], "R2 R3 R8 R9 exe_seq", int'(exe_seq[s*SW +: SW]), es[s]);
        chk(int'(exe_tid[s]) == et[s], "R11 exe_tid", int'(exe_tid[s]), et[s]);
        chk(int'(exe_cls[s*2 +: 2]) == ec[s], "R7 R9 exe_cls", int'(exe_cls[s*2 +: 2]), ec[s]);
      end
    end
    for (int c = 0; c < NC; c++) begin
      chk(fu_release[c] == erel[c], "R7 R8 R9 fu_release", int'(fu_release[c]), int'(erel[c]));
      chk(q_full[c] == (mq[c].size() >= QD), "R1 q_full", int'(q_full[c]), int'(mq[c].size() >= QD));
    end
    for (int t = 0; t < 2; t++) begin
      automatic int cnt = 0;
      for (int c = 0; c < NC; c++) foreach (mq[c][i]) if (mq[c][i].tid == t) cnt++;
      chk(int'(thr_count[t*CWB +: CWB]) == cnt, "R11 thr_count", int'(thr_count[t*CWB +: CWB]), cnt);
    end
    clr();
  endtask

  initial begin
    #1000000;
    errs++; nchk++;
    $display("FAIL R12 watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin mdv[c] = 0; mcnt[c] = 0; mseq[c] = 0; mtid[c] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk(exe_valid == '0, "R12 reset exe_valid", int'(exe_valid), 0);
    chk(fu_release == '0, "R12 reset fu_release", int'(fu_release), 0);
    chk(q_full == '0, "R12 reset q_full", int'(q_full), 0);
    chk(thr_count == '0, "R12 reset thr_count", int'(thr_count), 0);
    rst_n = 1'b1;

    // age order across classes and width limit (R3 R4)
    fu_free = '1;
    setpush(1, 1, 0, 0); setpush(2, 2, 1, 0); setpush(0, 3, 0, 0);
    cyc(); repeat (3) cyc();

    // out-of-order pushes, full queue, blocked unit (R1 R2 R6)
    fu_free = 4'b1101;
    setpush(1, 40, 0, 0); cyc();
    setpush(1, 35, 1, 0); cyc();
    setpush(1, 38, 0, 0); cyc();
    setpush(1, 30, 1, 0); cyc();
    setpush(1, 50, 0, 0); cyc();
    chk(q_full[1] == 1'b1, "R1 class 1 full", int'(q_full[1]), 1);
    cyc();
    fu_free = '1;
    repeat (5) cyc();

    // squashed head dropped without a slot (R5)
    setpush(0, 60, 0, 0); setpush(1, 61, 1, 0); setpush(2, 62, 0, 0); cyc();
    head_squash[0] = 1'b1; cyc();
    repeat (2) cyc();

    // long issue latency colliding with direct issues (R9 R10)
    setpush(3, 70, 1, 0); cyc();
    cyc();
    setpush(0, 73, 0, 0); setpush(1, 74, 0, 0); setpush(2, 75, 1, 0); cyc();
    repeat (5) cyc();

    // memory entry held until completion (R11)
    setpush(2, 80, 1, 1); cyc();
    repeat (2) cyc();
    chk(int'(thr_count[CWB +: CWB]) == 1, "R11 memory entry held", int'(thr_count[CWB +: CWB]), 1);
    done_valid = 1'b1; done_cls = 2'd2; done_seq = SW'(80); cyc();
    chk(int'(thr_count[CWB +: CWB]) == 0, "R11 memory entry freed", int'(thr_count[CWB +: CWB]), 0);

    // mixed random traffic
    for (int n = 0; n < 2500; n++) begin
      fu_free = 4'($urandom);
      if ($urandom % 6 == 0) head_squash = 4'($urandom);
      for (int c = 0; c < NC; c++)
        if ($urandom % 4 == 0 && gs < 1000) begin
          setpush(c, gs, int'($urandom % 2), ($urandom % 4) == 0);
          gs++;
        end
      if ($urandom % 3 == 0) begin
        automatic bit found = 0;
        for (int c = 0; c < NC; c++)
          foreach (mq[c][i])
            if (!found && mq[c][i].held) begin
              found = 1; done_valid = 1'b1; done_cls = 2'(c); done_seq = SW'(mq[c][i].seq);
            end
      end
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule